// File: doc/BRIEF.md
# Paged Buffer Address Translator

This block sits between a 24-bit network-controller address bus and a shared packet RAM. Every access goes through a table of 1024 16-bit page descriptors. The address is split into a 10-bit descriptor index and a 10-bit byte offset, and the four highest address bits are discarded. The selected descriptor supplies a physical frame number, a byte-order flag and a memory-target flag. The block returns a physical byte address, byte enables, write data with the lanes steered, and read data with the lanes steered back. The same translation serves the controller and the host, so both see the packet RAM through one view.

The host programs descriptors through a separate table port. A write takes one cycle and is seen by any access issued in a later cycle. The table port also returns the descriptor at the requested index one cycle after it is requested. Transfers are either 16-bit words or single bytes; there are no wider transfers. A frame number beyond the installed RAM makes the access fail: it returns zero and never reaches the memory.

Top module: `page_xlate`

## Requirements
- R1: The physical byte address is the low 8 bits of the descriptor's frame field (bits 11:0) concatenated with address bits 9:0. Address bits 23:20 are ignored and bits 19:10 pick the descriptor. A 16-bit access forces address bit 0 to zero.
- R2: The table holds 1024 descriptors of 16 bits. A write on the table port is seen by accesses issued from the next cycle on; an access issued in the same cycle sees the old descriptor. mapRdData shows the descriptor at mapIdx one cycle after mapIdx is presented, taken before any write in that cycle.
- R3: Descriptor bit 15 clear means the page is little-endian: a 16-bit write goes out with its two bytes exchanged, and a 16-bit read comes back exchanged. With bit 15 set, data passes unchanged.
- R4: Descriptor bit 13 set raises memAuxSel for the access, routing it to the auxiliary bus memory; clear leaves it on on-board RAM.
- R5: A byte access uses accWrData[7:0] and returns its byte in accRdData[7:0] with bits 15:8 zero. On a page with bit 15 set, an even address uses lane 15:8 (memByteEn=2'b10) and an odd address uses lane 7:0 (2'b01). On a swapped page the lanes are reversed. Byte write data is copied onto both lanes, and a 16-bit access uses memByteEn=2'b11.
- R6: A frame field of 256 or more makes accRangeErr high in the response cycle. In that case memValid stays low and accRdData is zero.
- R7: The response appears exactly one cycle after accValid and only then. accRdData is zero except in the response to a valid read.
- R8: After reset all outputs are zero and every descriptor reads as zero.
- R9: Descriptor 1023 covers the top of the address space. Loaded with the same frame as descriptor 0, it makes address 0xFFFFF4 reach the same byte as 0x0003F4.
- R10: Descriptor bits 14 and 12 have no effect on the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapWe | input | 1 | Write the descriptor at mapIdx this cycle |
| mapIdx | input | 10 | Descriptor index for table write and readback |
| mapWrData | input | 16 | Descriptor value to write |
| mapRdData | output | 16 | Descriptor at the previous cycle's mapIdx |
| accValid | input | 1 | Access request |
| accWrite | input | 1 | 1 = write, 0 = read |
| accWide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| accAddr | input | 24 | Bus-side byte address |
| accWrData | input | 16 | Write data (byte accesses use bits 7:0) |
| accRdData | output | 16 | Steered read data in the response cycle |
| accRangeErr | output | 1 | Frame out of range in the response cycle |
| memValid | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write strobe |
| memAuxSel | output | 1 | Auxiliary bus memory selected |
| memAddr | output | 18 | Physical byte address |
| memByteEn | output | 2 | Lane enables, bit 1 = bits 15:8 |
| memWrData | output | 16 | Steered write data |
| memRdData | input | 16 | Memory read data in the response cycle |

## Verification
The bench builds the block with its default parameters: a 10-bit index, a 10-bit offset, and 256 installed frames. With those values the full 1024-entry table and the very last descriptor (index 1023) are reachable, so the top-of-space alias can be checked. The frame 255 / frame 256 boundary of the range check is also reachable, and so is a frame field with its upper bits set. Memory read data is a function of the address, so a wrong address or a wrong lane exchange shows up as wrong read data.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int ENTRY_W    = 16;
  localparam int ORDER_BIT  = 15;  // set: host byte order, no exchange
  localparam int TARGET_BIT = 13;  // set: auxiliary bus memory
  localparam int FRAME_MSB  = 11;  // frame field is [FRAME_MSB:0]

  typedef struct packed {
    logic valid;
    logic write;
    logic wide;
    logic swap;
    logic laneHigh;
    logic aux;
    logic rangeErr;
  } xlateStb_t;

  function automatic logic [15:0] byteExchange(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/page_xlate_map.sv
module page_xlate_map
  import page_xlate_pkg::*;
#(
  parameter int IDX_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mapWe,
  input  logic [IDX_BITS-1:0] mapIdx,
  input  logic [ENTRY_W-1:0]  mapWrData,
  output logic [ENTRY_W-1:0]  mapRdData,
  input  logic [IDX_BITS-1:0] lookIdx,
  output logic [ENTRY_W-1:0]  lookEntry
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [ENTRY_W-1:0] table_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
      mapRdData <= '0;
    end else begin
      if (mapWe) table_q[mapIdx] <= mapWrData;
      mapRdData <= table_q[mapIdx];
    end
  end

  assign lookEntry = table_q[lookIdx];
endmodule

// File: rtl/page_xlate_ctrl.sv
module page_xlate_ctrl
  import page_xlate_pkg::*;
#(
  parameter int NUM_PAGES = 256
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic               accWide,
  input  logic               addrLsb,
  input  logic [ENTRY_W-1:0] lookEntry,
  output xlateStb_t          stbNext,
  output xlateStb_t          stb
);
  logic [FRAME_MSB:0] frame;
  logic               swapPage;
  logic               outOfRange;

  assign frame      = lookEntry[FRAME_MSB:0];
  assign swapPage   = ~lookEntry[ORDER_BIT];
  assign outOfRange = (32'(frame) >= NUM_PAGES);

  always_comb begin
    stbNext.valid    = accValid;
    stbNext.write    = accWrite;
    stbNext.wide     = accWide;
    stbNext.swap     = swapPage;
    // even byte lives in the high lane on a host-order page
    stbNext.laneHigh = ~(addrLsb ^ swapPage);
    stbNext.aux      = lookEntry[TARGET_BIT];
    stbNext.rangeErr = outOfRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stb <= '0;
    else       stb <= stbNext;
  end
endmodule

// File: rtl/page_xlate_dp.sv
module page_xlate_dp
  import page_xlate_pkg::*;
#(
  parameter int PAGE_BITS  = 10,
  parameter int FRAME_BITS = 8,
  localparam int PHYS_AW   = PAGE_BITS + FRAME_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic [PAGE_BITS-1:0] pageOff,
  input  logic [15:0]          accWrData,
  input  logic [ENTRY_W-1:0]   lookEntry,
  input  xlateStb_t            stbNext,
  input  xlateStb_t            stb,
  input  logic [15:0]          memRdData,
  output logic [15:0]          accRdData,
  output logic                 accRangeErr,
  output logic                 memValid,
  output logic                 memWe,
  output logic                 memAuxSel,
  output logic [PHYS_AW-1:0]   memAddr,
  output logic [1:0]           memByteEn,
  output logic [15:0]          memWrData
);
  logic [PAGE_BITS-1:0] offNext;
  logic [15:0]          wrNext;

  assign offNext = stbNext.wide ? {pageOff[PAGE_BITS-1:1], 1'b0} : pageOff;

  always_comb begin
    if (stbNext.wide) wrNext = stbNext.swap ? byteExchange(accWrData) : accWrData;
    else              wrNext = {accWrData[7:0], accWrData[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memWrData <= '0;
    end else if (accValid) begin
      memAddr   <= {lookEntry[FRAME_BITS-1:0], offNext};
      memWrData <= wrNext;
    end
  end

  assign memValid    = stb.valid & ~stb.rangeErr;
  assign memWe       = memValid & stb.write;
  assign memAuxSel   = memValid & stb.aux;
  assign accRangeErr = stb.valid & stb.rangeErr;

  always_comb begin
    if (!memValid)     memByteEn = 2'b00;
    else if (stb.wide) memByteEn = 2'b11;
    else               memByteEn = stb.laneHigh ? 2'b10 : 2'b01;
  end

  always_comb begin
    accRdData = '0;
    if (memValid && !stb.write) begin
      if (stb.wide) accRdData = stb.swap ? byteExchange(memRdData) : memRdData;
      else          accRdData = {8'h00, stb.laneHigh ? memRdData[15:8] : memRdData[7:0]};
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_BITS = 10,
  parameter int IDX_BITS  = 10,
  parameter int NUM_PAGES = 256,
  localparam int FRAME_BITS = $clog2(NUM_PAGES),
  localparam int PHYS_AW    = PAGE_BITS + FRAME_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mapWe,
  input  logic [IDX_BITS-1:0] mapIdx,
  input  logic [15:0]         mapWrData,
  output logic [15:0]         mapRdData,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic                accWide,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [15:0]         accWrData,
  output logic [15:0]         accRdData,
  output logic                accRangeErr,
  output logic                memValid,
  output logic                memWe,
  output logic                memAuxSel,
  output logic [PHYS_AW-1:0]  memAddr,
  output logic [1:0]          memByteEn,
  output logic [15:0]         memWrData,
  input  logic [15:0]         memRdData
);
  logic [ENTRY_W-1:0] lookEntry;
  xlateStb_t          stbNext;
  xlateStb_t          stb;

  page_xlate_map #(.IDX_BITS(IDX_BITS)) u_map (
    .clk, .rstN, .mapWe, .mapIdx, .mapWrData, .mapRdData,
    .lookIdx  (accAddr[PAGE_BITS +: IDX_BITS]),
    .lookEntry(lookEntry)
  );

  page_xlate_ctrl #(.NUM_PAGES(NUM_PAGES)) u_ctrl (
    .clk, .rstN, .accValid, .accWrite, .accWide,
    .addrLsb  (accAddr[0]),
    .lookEntry(lookEntry),
    .stbNext  (stbNext),
    .stb      (stb)
  );

  page_xlate_dp #(.PAGE_BITS(PAGE_BITS), .FRAME_BITS(FRAME_BITS)) u_dp (
    .clk, .rstN, .accValid,
    .pageOff  (accAddr[PAGE_BITS-1:0]),
    .accWrData, .lookEntry, .stbNext, .stb, .memRdData,
    .accRdData, .accRangeErr, .memValid, .memWe, .memAuxSel,
    .memAddr, .memByteEn, .memWrData
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int ADDR_W  = 24,
  parameter int PHYS_AW = 18
) (
  input logic               clk,
  input logic               rstN,
  input logic               accValid,
  input logic               accWrite,
  input logic               accWide,
  input logic [15:0]        accRdData,
  input logic               accRangeErr,
  input logic               memValid,
  input logic               memWe,
  input logic [PHYS_AW-1:0] memAddr,
  input logic [1:0]         memByteEn
);
  a_r6_err_blocks_mem: assert property (@(posedge clk) disable iff (!rstN)
    accRangeErr |-> !memValid && accRdData == 16'h0);

  a_r7_resp_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || accRangeErr) |-> $past(accValid));

  a_r7_write_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(accWrite) && memValid);

  a_r5_lanes_enabled: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memByteEn != 2'b00 && ($past(accWide) == (memByteEn == 2'b11)));

  a_r5_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWe && !$past(accWide)) |-> accRdData[15:8] == 8'h00);

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memByteEn == 2'b11) |-> memAddr[0] == 1'b0);
endmodule

bind page_xlate page_xlate_chk #(.ADDR_W(ADDR_W), .PHYS_AW(PHYS_AW)) u_chk (.*);

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapWe = 1'b0;
  logic [9:0]  mapIdx = '0;
  logic [15:0] mapWrData = '0;
  logic [15:0] mapRdData;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic        accWide = 1'b0;
  logic [23:0] accAddr = '0;
  logic [15:0] accWrData = '0;
  logic [15:0] accRdData;
  logic        accRangeErr;
  logic        memValid, memWe, memAuxSel;
  logic [17:0] memAddr;
  logic [1:0]  memByteEn;
  logic [15:0] memWrData;
  logic [15:0] memRdData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] ramFn(input logic [17:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ {6'b0, a[17:16]}};
  endfunction
  assign memRdData = ramFn(memAddr);

  page_xlate u_dut (.*);

  // reference state
  logic [15:0] mdl [1024];
  logic        pMapWe = 0;
  logic [9:0]  pMapIdx = 0;
  logic [15:0] pMapDat = 0;
  logic        pV = 0, pW = 0, pWide = 0;
  logic [23:0] pA = 0;
  logic [15:0] pD = 0;
  string       pTag = "R7";
  bit          pArmed = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] xch(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic checkPending();
    logic [15:0] e;
    logic [11:0] fr;
    logic        sw, lh;
    logic [17:0] ad;
    logic [15:0] rd;
    if (!pArmed) return;
    chk(pTag, "mapRdData", mapRdData, mdl[pMapIdx]);
    if (!pV) begin
      chk(pTag, "idle memValid", memValid, 0);
      chk(pTag, "idle accRangeErr", accRangeErr, 0);
      chk(pTag, "idle accRdData", accRdData, 0);
      return;
    end
    e  = mdl[pA[19:10]];
    fr = e[11:0];
    sw = ~e[15];
    lh = ~(pA[0] ^ sw);
    ad = {fr[7:0], pWide ? {pA[9:1], 1'b0} : pA[9:0]};
    if (fr >= 12'd256) begin
      chk(pTag, "accRangeErr", accRangeErr, 1);
      chk(pTag, "memValid on error", memValid, 0);
      chk(pTag, "accRdData on error", accRdData, 0);
      return;
    end
    chk(pTag, "accRangeErr", accRangeErr, 0);
    chk(pTag, "memValid", memValid, 1);
    chk(pTag, "memWe", memWe, pW);
    chk(pTag, "memAddr", memAddr, ad);
    chk(pTag, "memAuxSel", memAuxSel, e[13]);
    chk(pTag, "memByteEn", memByteEn, pWide ? 2'b11 : (lh ? 2'b10 : 2'b01));
    if (pW) begin
      chk(pTag, "memWrData", memWrData, pWide ? (sw ? xch(pD) : pD) : {pD[7:0], pD[7:0]});
      chk(pTag, "accRdData on write", accRdData, 0);
    end else begin
      rd = ramFn(ad);
      chk(pTag, "accRdData", accRdData,
          pWide ? (sw ? xch(rd) : rd) : {8'h00, lh ? rd[15:8] : rd[7:0]});
    end
  endtask

  task automatic step(input logic mW, input logic [9:0] mI, input logic [15:0] mD,
                      input logic aV, input logic aW, input logic aWide,
                      input logic [23:0] aA, input logic [15:0] aD, input string tag);
    @(negedge clk);
    checkPending();
    if (pArmed && pMapWe) mdl[pMapIdx] = pMapDat;
    mapWe = mW; mapIdx = mI; mapWrData = mD;
    accValid = aV; accWrite = aW; accWide = aWide; accAddr = aA; accWrData = aD;
    pMapWe = mW; pMapIdx = mI; pMapDat = mD;
    pV = aV; pW = aW; pWide = aWide; pA = aA; pD = aD; pTag = tag;
    pArmed = 1;
  endtask

  task automatic wrMap(input logic [9:0] i, input logic [15:0] d);
    step(1, i, d, 0, 0, 0, 0, 0, "R2");
  endtask
  task automatic acc(input logic w, input logic wide, input logic [23:0] a, input logic [15:0] d, input string tag);
    step(0, a[19:10], 0, 1, w, wide, a, d, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected<=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    chk("R8", "reset memValid", memValid, 0);
    chk("R8", "reset accRangeErr", accRangeErr, 0);
    chk("R8", "reset accRdData", accRdData, 0);
    chk("R8", "reset mapRdData", mapRdData, 0);
    chk("R8", "reset memByteEn", memByteEn, 0);
    rstN = 1'b1;
    step(0, 10'd512, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 10'd1023, 0, 0, 0, 0, 0, 0, "R8");

    wrMap(10'd0,    16'h8005);   // host order, frame 5
    wrMap(10'd1,    16'h0007);   // swapped, frame 7
    wrMap(10'd2,    16'hA009);   // host order, aux, frame 9
    wrMap(10'd3,    16'h8100);   // frame 256
    wrMap(10'd4,    16'h80FF);   // frame 255
    wrMap(10'd1023, 16'h8005);   // alias of entry 0
    wrMap(10'd5,    16'h5003);   // bits 14,12 set, swapped, frame 3
    wrMap(10'd6,    16'h8FFF);   // frame 4095
    step(0, 10'd2, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 10'd5, 0, 0, 0, 0, 0, 0, "R2");

    acc(0, 1, 24'h0003F4, 0, "R1");
    acc(0, 1, 24'hF003F5, 0, "R1");
    acc(0, 1, 24'hFFFFF4, 0, "R9");
    acc(0, 0, 24'hFFFFF5, 0, "R9");
    acc(1, 1, 24'h000412, 16'h1234, "R3");
    acc(0, 1, 24'h000412, 0, "R3");
    acc(1, 1, 24'h000010, 16'hBEEF, "R3");
    acc(0, 0, 24'h000020, 0, "R5");
    acc(0, 0, 24'h000021, 0, "R5");
    acc(0, 0, 24'h000420, 0, "R5");
    acc(0, 0, 24'h000421, 0, "R5");
    acc(1, 0, 24'h000030, 16'h00A7, "R5");
    acc(1, 0, 24'h000431, 16'hFF5C, "R5");
    acc(0, 1, 24'h000800, 0, "R4");
    acc(1, 0, 24'h0009FF, 16'h0011, "R4");
    acc(0, 1, 24'h000C00, 0, "R6");
    acc(1, 0, 24'h000C01, 16'h0042, "R6");
    acc(0, 0, 24'h001800, 0, "R6");
    acc(0, 1, 24'h0013FE, 0, "R6");
    acc(0, 1, 24'h001402, 0, "R10");
    acc(0, 0, 24'h001403, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");

    // R2: write and access in the same cycle, then the next cycle
    step(1, 10'd7, 16'h8011, 1, 0, 1, 24'h001C10, 0, "R2");
    acc(0, 1, 24'h001C10, 0, "R2");
    step(1, 10'd7, 16'h2022, 0, 0, 0, 0, 0, "R2");
    acc(0, 0, 24'h001C11, 0, "R2");

    // sweep across the table
    for (int i = 0; i < 64; i++)
      wrMap(10'(i * 16 + 8), 16'((i[0] ? 16'h8000 : 16'h0) | (i[1] ? 16'h2000 : 16'h0) | (i * 5 + 1)));
    for (int i = 0; i < 64; i++) begin
      acc(i[2], i[3], {4'(i), 10'(i * 16 + 8), 10'(i * 37)}, 16'(i * 16'h1357), "R1");
      if (i[4]) step(0, 10'(i), 0, 0, 0, 0, 0, 0, "R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule